// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block tracks which power mode the chip is in and moves it between modes. It models seven modes: normal run, very-low-power run, very-low-power wait, full stop, partial stop, very-low-power stop, and very-low-leakage stop. The leakage stop mode carries a sub-level.

Transitions are driven by four kinds of input. The first is a set of register-style selects: a run-mode code, a stop-mode code, a partial-stop option and a leakage sub-level. The second is a core sleep request, qualified by a deep-sleep flag. The third is a pair of write-once allow bits that gate the very-low-power and leakage modes. The last is a set of wake sources: an interrupt, an enabled low-power-timer wakeup and the reset pin.

The controller reports three things. It gives the current mode on a 4-bit code and pulses a strobe for one cycle on every change. It keeps a flag that records whether very-low-power stop was entered straight from run, and that flag decides where the exit goes. Clock limiting and power gating are handled outside the block.

Top module: `pwr_mode_seq`

State names, with their `mode_o` codes:

| State | Code | Meaning |
|---|---|---|
| PM_RUN | 0 | normal run |
| PM_VLPR | 1 | very-low-power run |
| PM_VLPW | 2 | very-low-power wait |
| PM_STOP | 3 | full stop |
| PM_PSTOP | 4 | partial stop |
| PM_VLPS | 5 | very-low-power stop |
| PM_VLLS | 6 | very-low-leakage stop |

Transitions, all taken on a rising clock edge:

| Transition | Condition |
|---|---|
| RUN to VLPR | no sleep request, the very-low-power allow bit is set, and `run_sel_i` is 2'b10 |
| VLPR to RUN | `run_sel_i` is 2'b00 |
| VLPR to VLPW | sleep request with the deep flag clear |
| VLPW to VLPR | interrupt |
| VLPR to VLPS | deep sleep with stop code 3'b000 or 3'b010 |
| RUN to VLPS | deep sleep, stop code 3'b010, and the very-low-power allow bit is set |
| VLPS exit | interrupt; goes to RUN if the entry flag is set, otherwise to VLPR |
| RUN to STOP or PSTOP | deep sleep with stop code 3'b000 |
| STOP or PSTOP to RUN | interrupt |
| RUN or VLPR to VLLS | deep sleep, stop code 3'b100, and the leakage allow bit is set |
| VLLS to RUN | `wkup_i` and `wkup_en_i` both high |
| Any state to RUN | `rst_n` low |

## Requirements
- R1: While `rst_n` is low, the controller is forced asynchronously to PM_RUN. The strobe, the entry flag and the level output all read 0, and both allow bits are cleared.
- R2: `mode_o` carries the state code listed in the brief. `mode_chg_o` is high for exactly the one cycle in which `mode_o` shows a new value, and it is low in every other cycle.
- R3: The first `allow_wr_i` pulse after reset latches `allow_i` (bit 0 is the very-low-power allow, bit 1 is the leakage allow). Every later write is ignored until the next reset.
- R4: PM_RUN moves to PM_VLPR when there is no sleep request, the very-low-power allow bit is set and `run_sel_i` is 2'b10. PM_VLPR returns to PM_RUN when `run_sel_i` is 2'b00. In PM_VLPR this return takes priority over a sleep request.
- R5: In PM_VLPR, a sleep request with `deep_i` low enters PM_VLPW. PM_VLPW leaves only on `irq_i` (to PM_VLPR) or on reset.
- R6: In PM_VLPR, a deep sleep with `stop_sel_i` equal to 3'b000 or 3'b010 enters PM_VLPS with the entry flag cleared. An interrupt then returns the controller to PM_VLPR.
- R7: In PM_RUN, a deep sleep with `stop_sel_i` equal to 3'b010 and the very-low-power allow bit set enters PM_VLPS and sets `vlps_from_run_o`. An interrupt then returns the controller to PM_RUN and clears the flag.
- R8: In PM_RUN, a deep sleep with `stop_sel_i` equal to 3'b000 enters PM_PSTOP when `pstop_opt_i` is 2'b01 or 2'b10, and PM_STOP for any other value. An interrupt returns either of these modes to PM_RUN.
- R9: From PM_RUN or PM_VLPR, a deep sleep with `stop_sel_i` equal to 3'b100 and the leakage allow bit set enters PM_VLLS. `leak_lvl_i` is latched onto `leak_lvl_o` at that entry.
- R10: PM_VLLS leaves only when `wkup_i` and `wkup_en_i` are both high, going to PM_RUN, or on reset. `irq_i` and a wakeup that is not enabled have no effect in this mode.
- R11: A request whose allow bit is clear is ignored, and so is a stop code other than 3'b000, 3'b010 or 3'b100. The mode stays where it is and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | reset pin, active low, asynchronous |
| allow_wr_i | input | 1 | write pulse for the allow bits |
| allow_i | input | 2 | allow data: bit 0 very-low-power, bit 1 leakage |
| run_sel_i | input | 2 | run-mode select |
| stop_sel_i | input | 3 | stop-mode select |
| pstop_opt_i | input | 2 | partial-stop option |
| leak_lvl_i | input | LVL_W | leakage sub-level select |
| sleep_req_i | input | 1 | core sleep request |
| deep_i | input | 1 | deep-sleep qualifier |
| irq_i | input | 1 | interrupt wake |
| wkup_i | input | 1 | low-power-timer wakeup |
| wkup_en_i | input | 1 | enable for the timer wakeup |
| mode_o | output | 4 | current mode code |
| mode_chg_o | output | 1 | one-cycle strobe on each mode change |
| leak_lvl_o | output | LVL_W | sub-level latched on leakage stop entry |
| vlps_from_run_o | output | 1 | very-low-power stop was entered from run |

## Verification
The bench enters very-low-power stop from both run and very-low-power run and checks each exit. A design that ignored the entry flag would send one of those two exits to the wrong mode.

It also repeats the allow write with different data after reset. A design that is not write-once would then open the leakage path too early.

In leakage stop the bench raises interrupts and a wakeup that is not enabled. A design that honoured either would leave the mode early.

Finally, it drives partial-stop option 2'b11 and an undefined stop code, and it asserts reset while in a wait state. These catch a partial-stop decode that is too broad, a request that is acted on when it should be dropped, and a reset that fails to return the controller to run.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        PM_RUN   = 4'd0,
        PM_VLPR  = 4'd1,
        PM_VLPW  = 4'd2,
        PM_STOP  = 4'd3,
        PM_PSTOP = 4'd4,
        PM_VLPS  = 4'd5,
        PM_VLLS  = 4'd6
    } pm_mode_e;

    // Classified sleep request, one flag per kind of request
    typedef struct packed {
        logic nap;        // sleep with the deep flag clear
        logic deep_zero;  // deep sleep, stop code 000
        logic deep_vlps;  // deep sleep, stop code 010
        logic deep_leak;  // deep sleep, stop code 100
        logic part;       // partial-stop option selects partial stop
    } sleep_req_t;

endpackage

// File: rtl/pmc_allow_reg.sv
module pmc_allow_reg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    logic locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o    <= '0;
            locked <= 1'b0;
        end else if (wr_i && !locked) begin
            q_o    <= d_i;
            locked <= 1'b1;
        end
    end

    // R3: once the bits are locked, they hold their value
    p_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(q_o));

endmodule

// File: rtl/pmc_req_decode.sv
module pmc_req_decode
    import pmc_pkg::*;
#(
    parameter int STOP_W = 3,
    parameter int OPT_W  = 2
) (
    input  logic              sleep_req_i,
    input  logic              deep_i,
    input  logic [STOP_W-1:0] stop_sel_i,
    input  logic [OPT_W-1:0]  pstop_opt_i,
    output sleep_req_t        req_o
);
    localparam logic [STOP_W-1:0] SEL_ZERO = STOP_W'(0);
    localparam logic [STOP_W-1:0] SEL_VLPS = STOP_W'(2);
    localparam logic [STOP_W-1:0] SEL_LEAK = STOP_W'(4);

    logic deep_sleep;

    always_comb begin
        deep_sleep      = sleep_req_i && deep_i;
        req_o.nap       = sleep_req_i && !deep_i;
        req_o.deep_zero = deep_sleep && (stop_sel_i == SEL_ZERO);
        req_o.deep_vlps = deep_sleep && (stop_sel_i == SEL_VLPS);
        req_o.deep_leak = deep_sleep && (stop_sel_i == SEL_LEAK);
        req_o.part      = (pstop_opt_i == OPT_W'(1)) || (pstop_opt_i == OPT_W'(2));
    end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pmc_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             allow_wr_i,
    input  logic [1:0]       allow_i,
    input  logic [1:0]       run_sel_i,
    input  logic [2:0]       stop_sel_i,
    input  logic [1:0]       pstop_opt_i,
    input  logic [LVL_W-1:0] leak_lvl_i,
    input  logic             sleep_req_i,
    input  logic             deep_i,
    input  logic             irq_i,
    input  logic             wkup_i,
    input  logic             wkup_en_i,
    output logic [3:0]       mode_o,
    output logic             mode_chg_o,
    output logic [LVL_W-1:0] leak_lvl_o,
    output logic             vlps_from_run_o
);
    localparam int ALLOW_N = 2;

    logic [ALLOW_N-1:0] allow_q;
    logic               al_vlp, al_lls;
    sleep_req_t         sr;
    pm_mode_e           st, nxt;
    logic               flag_q, nxt_flag;

    pmc_allow_reg #(.N(ALLOW_N)) u_allow (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (allow_wr_i),
        .d_i   (allow_i),
        .q_o   (allow_q)
    );

    assign al_vlp = allow_q[0];
    assign al_lls = allow_q[1];

    pmc_req_decode #(.STOP_W(3), .OPT_W(2)) u_dec (
        .sleep_req_i (sleep_req_i),
        .deep_i      (deep_i),
        .stop_sel_i  (stop_sel_i),
        .pstop_opt_i (pstop_opt_i),
        .req_o       (sr)
    );

    // Next-state selection
    always_comb begin
        nxt      = st;
        nxt_flag = flag_q;
        unique case (st)
            PM_RUN: begin
                if (sr.deep_zero) begin
                    nxt = sr.part ? PM_PSTOP : PM_STOP;
                end else if (sr.deep_vlps && al_vlp) begin
                    nxt      = PM_VLPS;
                    nxt_flag = 1'b1;
                end else if (sr.deep_leak && al_lls) begin
                    nxt = PM_VLLS;
                end else if (!sleep_req_i && al_vlp && run_sel_i == 2'b10) begin
                    nxt = PM_VLPR;
                end
            end
            PM_VLPR: begin
                if (run_sel_i == 2'b00) begin
                    nxt = PM_RUN;
                end else if (sr.nap) begin
                    nxt = PM_VLPW;
                end else if (sr.deep_zero || sr.deep_vlps) begin
                    nxt      = PM_VLPS;
                    nxt_flag = 1'b0;
                end else if (sr.deep_leak && al_lls) begin
                    nxt = PM_VLLS;
                end
            end
            PM_VLPW: begin
                if (irq_i) nxt = PM_VLPR;
            end
            PM_STOP, PM_PSTOP: begin
                if (irq_i) nxt = PM_RUN;
            end
            PM_VLPS: begin
                if (irq_i) begin
                    nxt      = flag_q ? PM_RUN : PM_VLPR;
                    nxt_flag = 1'b0;
                end
            end
            PM_VLLS: begin
                if (wkup_i && wkup_en_i) nxt = PM_RUN;
            end
            default: nxt = PM_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= PM_RUN;
            flag_q <= 1'b0;
        end else begin
            st     <= nxt;
            flag_q <= nxt_flag;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_chg_o <= 1'b0;
            leak_lvl_o <= '0;
        end else begin
            mode_chg_o <= (nxt != st);
            if (nxt == PM_VLLS && st != PM_VLLS) leak_lvl_o <= leak_lvl_i;
        end
    end

    assign mode_o          = st;
    assign vlps_from_run_o = flag_q;

    // R2: the strobe marks exactly the cycles in which the mode is new
    p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg_o == (mode_o != $past(mode_o)));

    // R5: wait mode goes nowhere except back to very-low-power run
    p_wait_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PM_VLPW) |=> (st == PM_VLPW || st == PM_VLPR));

    // R7: an interrupt in stop entered from run returns to run
    p_vlps_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PM_VLPS && flag_q && irq_i) |=> (st == PM_RUN && !flag_q));

    // R10: leakage stop holds without an enabled wakeup
    p_vlls_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PM_VLLS && !(wkup_i && wkup_en_i)) |=> (st == PM_VLLS));

    // R11: very-low-power run is reached only when allowed
    p_vlpr_allow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PM_RUN && !al_vlp) |=> (st != PM_VLPR && st != PM_VLPS));

endmodule

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       allow_wr_i = 1'b0;
    logic [1:0] allow_i = 2'b00;
    logic [1:0] run_sel_i = 2'b00;
    logic [2:0] stop_sel_i = 3'b000;
    logic [1:0] pstop_opt_i = 2'b00;
    logic [1:0] leak_lvl_i = 2'b00;
    logic       sleep_req_i = 1'b0, deep_i = 1'b0, irq_i = 1'b0;
    logic       wkup_i = 1'b0, wkup_en_i = 1'b0;
    logic [3:0] mode_o;
    logic       mode_chg_o, vlps_from_run_o;
    logic [1:0] leak_lvl_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference state
    int m_mode = 0, m_flag = 0, m_lvl = 0, m_chg = 0, m_allow = 0, m_locked = 0;

    always #4 clk = ~clk;   // 125 MHz

    pwr_mode_seq dut_i (
        .clk(clk), .rst_n(rst_n), .allow_wr_i(allow_wr_i), .allow_i(allow_i),
        .run_sel_i(run_sel_i), .stop_sel_i(stop_sel_i), .pstop_opt_i(pstop_opt_i),
        .leak_lvl_i(leak_lvl_i), .sleep_req_i(sleep_req_i), .deep_i(deep_i),
        .irq_i(irq_i), .wkup_i(wkup_i), .wkup_en_i(wkup_en_i),
        .mode_o(mode_o), .mode_chg_o(mode_chg_o), .leak_lvl_o(leak_lvl_o),
        .vlps_from_run_o(vlps_from_run_o)
    );

    task automatic check(string tag, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare(string tag);
        check(tag, "mode", int'(mode_o), m_mode);
        check(tag, "strobe", int'(mode_chg_o), m_chg);
        check(tag, "flag", int'(vlps_from_run_o), m_flag);
        check(tag, "level", int'(leak_lvl_o), m_lvl);
    endtask

    // advance the reference by one clock using the current inputs
    function automatic void model_tick();
        int nm = m_mode;
        int nf = m_flag;
        bit vlp = m_allow[0];
        bit lls = m_allow[1];
        bit deep = sleep_req_i && deep_i;
        if (m_mode == 0) begin
            if (deep && stop_sel_i == 0) nm = (pstop_opt_i == 1 || pstop_opt_i == 2) ? 4 : 3;
            else if (deep && stop_sel_i == 2 && vlp) begin nm = 5; nf = 1; end
            else if (deep && stop_sel_i == 4 && lls) nm = 6;
            else if (!sleep_req_i && vlp && run_sel_i == 2) nm = 1;
        end else if (m_mode == 1) begin
            if (run_sel_i == 0) nm = 0;
            else if (sleep_req_i && !deep_i) nm = 2;
            else if (deep && (stop_sel_i == 0 || stop_sel_i == 2)) begin nm = 5; nf = 0; end
            else if (deep && stop_sel_i == 4 && lls) nm = 6;
        end else if (m_mode == 2) begin
            if (irq_i) nm = 1;
        end else if (m_mode == 3 || m_mode == 4) begin
            if (irq_i) nm = 0;
        end else if (m_mode == 5) begin
            if (irq_i) begin nm = (m_flag != 0) ? 0 : 1; nf = 0; end
        end else if (m_mode == 6) begin
            if (wkup_i && wkup_en_i) nm = 0;
        end
        if (nm == 6 && m_mode != 6) m_lvl = leak_lvl_i;
        m_chg  = (nm != m_mode);
        m_mode = nm;
        m_flag = nf;
        if (allow_wr_i && !m_locked) begin m_allow = allow_i; m_locked = 1; end
    endfunction

    task automatic step(string tag);
        @(posedge clk);
        model_tick();
        @(negedge clk);
        compare(tag);
        sleep_req_i = 0; deep_i = 0; irq_i = 0; wkup_i = 0; allow_wr_i = 0;
    endtask

    task automatic do_reset(string tag);
        rst_n = 0;
        m_mode = 0; m_flag = 0; m_lvl = 0; m_chg = 0; m_allow = 0; m_locked = 0;
        @(negedge clk);
        compare(tag);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic deep_sleep(logic [2:0] code, string tag);
        sleep_req_i = 1; deep_i = 1; stop_sel_i = code;
        step(tag);
    endtask

    initial begin
        @(negedge clk);
        do_reset("R1");
        step("R1");
        // R11: run select 10 without the allow bit is ignored
        run_sel_i = 2'b10; step("R11");
        deep_sleep(3'b010, "R11");
        // R3: first write latches very-low-power allow only
        allow_wr_i = 1; allow_i = 2'b01; step("R3");
        step("R4");                      // RUN -> VLPR
        step("R2");                      // strobe drops
        // R5: wait and back
        sleep_req_i = 1; deep_i = 0; step("R5");
        step("R5");
        irq_i = 1; step("R5");
        // R6: stop from very-low-power run, both codes
        deep_sleep(3'b000, "R6");
        irq_i = 1; step("R6");
        deep_sleep(3'b010, "R6");
        irq_i = 1; step("R6");
        // R3: a second write does not open the leakage path
        allow_wr_i = 1; allow_i = 2'b11; step("R3");
        deep_sleep(3'b100, "R3");
        deep_sleep(3'b111, "R11");
        // R4: return to run, priority over a sleep request
        run_sel_i = 2'b00; sleep_req_i = 1; deep_i = 0; step("R4");
        // R7: stop entered from run, exits to run
        deep_sleep(3'b010, "R7");
        step("R7");
        irq_i = 1; step("R7");
        // R8: full stop and partial stop
        pstop_opt_i = 2'b00; deep_sleep(3'b000, "R8");
        irq_i = 1; step("R8");
        pstop_opt_i = 2'b01; deep_sleep(3'b000, "R8");
        irq_i = 1; step("R8");
        pstop_opt_i = 2'b10; deep_sleep(3'b000, "R8");
        irq_i = 1; step("R8");
        pstop_opt_i = 2'b11; deep_sleep(3'b000, "R8");
        irq_i = 1; step("R8");
        deep_sleep(3'b110, "R11");
        // R1: reset from very-low-power wait
        run_sel_i = 2'b10; step("R4");
        sleep_req_i = 1; step("R5");
        do_reset("R1");
        step("R1");
        // R9/R10: leakage stop from run
        run_sel_i = 2'b00;
        allow_wr_i = 1; allow_i = 2'b10; step("R3");
        leak_lvl_i = 2'd3; deep_sleep(3'b100, "R9");
        leak_lvl_i = 2'd1;
        irq_i = 1; step("R10");
        wkup_i = 1; step("R10");
        wkup_en_i = 1; step("R10");
        wkup_i = 1; step("R10");
        // R11: very-low-power run still refused with only leakage allowed
        run_sel_i = 2'b10; step("R11");
        // R9: leakage stop from very-low-power run
        do_reset("R1");
        allow_wr_i = 1; allow_i = 2'b11; step("R3");
        step("R4");
        leak_lvl_i = 2'd2; deep_sleep(3'b100, "R9");
        irq_i = 1; step("R10");
        wkup_i = 1; step("R10");
        step("R2");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule